// File: doc/BRIEF.md
# Event-Triggered DMA Address Sequencer

This block is one channel of a DMA channel controller. Software loads a parameter set: source and destination start addresses, a byte count per array (ACNT), an array count per frame (BCNT), a frame count (CCNT), and signed 16-bit step values for the array and frame strides of each address. After the load, every synchronization event makes the channel issue exactly one request to move ACNT bytes. The channel then advances its addresses and counts, one array per event. This suits a video capture path, where each line-ready event moves one image line into memory.

Requests leave on a valid/ready interface. While `req_valid` is high and `req_ready` is low, the request fields hold still. A request completes on the first cycle in which both signals are high. The channel accepts no new event while a request is pending. Such an event is dropped and is recorded in a sticky flag.

A CPU read port exposes the live destination address so software can track how far a transfer has got. Every read is served from a value captured in a single clock cycle, so a 32-bit read can never mix bits of the old and new address. Narrow reads of byte lane 0 capture a snapshot of the whole word. Reads of the higher lanes are served from that snapshot, so a byte-by-byte walk through the register yields one coherent word.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset the channel is idle, with `busy`, `req_valid`, `done`, `missed_evt` and `rd_valid` all low. A `cfg_load` pulse loads the parameter set, clears `missed_evt`, and raises `busy` on the next cycle if and only if the loaded CCNT is nonzero.
- R2: An event that arrives while `busy` is high and no request is pending raises `req_valid` on the next cycle. The request carries `req_bytes`=ACNT and the source and destination addresses as they were before this event. All request fields hold while `req_valid` is high and `req_ready` is low.
- R3: On an event that is not the last array of a frame, both addresses advance by their array stride (sign-extended) and the remaining-array count decrements.
- R4: On the last array of a frame, both addresses advance by their frame stride instead, the array count reloads, and the frame count decrements. With BCNT equal to 1 this happens on every event. A whole transfer takes BCNT×CCNT events (BCNT of 0 is treated as 1).
- R5: The event that exhausts CCNT produces a `done` pulse exactly one cycle long, in the cycle where `busy` drops. Later events issue no request and leave the addresses unchanged until the next load.
- R6: An event that arrives while `req_valid` is high is dropped: no request is issued and the addresses do not advance. It sets `missed_evt`, which stays high until the next `cfg_load`.
- R7: A read with `cpu_rd_size`=2 (word) returns the full destination address on `rd_data` one cycle later, with `rd_valid` high for that cycle. If the read coincides with an address update, it returns the pre-update value.
- R8: For narrow reads, `cpu_rd_size`=0 selects a byte and 1 selects a halfword; `cpu_rd_off` is the byte offset; data is right-aligned and zero-filled. An access at offset 0 returns live data and captures a snapshot of the whole word. An access at a nonzero offset returns data taken from that snapshot.
- R9: When both destination strides are nonnegative, successive word reads of the destination address never decrease within one transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load parameter set pulse |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_acnt | input | CW | Bytes per array |
| cfg_bcnt | input | CW | Arrays per frame |
| cfg_ccnt | input | CW | Frames per transfer |
| cfg_src_astep | input | IW | Source array stride (signed) |
| cfg_dst_astep | input | IW | Destination array stride (signed) |
| cfg_src_fstep | input | IW | Source frame stride (signed) |
| cfg_dst_fstep | input | IW | Destination frame stride (signed) |
| sync_evt | input | 1 | Synchronization event |
| req_valid | output | 1 | Transfer request pending |
| req_ready | input | 1 | Data mover accepts request |
| req_src | output | AW | Request source address |
| req_dst | output | AW | Request destination address |
| req_bytes | output | CW | Request byte count |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| missed_evt | output | 1 | Sticky dropped-event flag |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_rd_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_rd_off | input | $clog2(AW/8) | Byte offset of narrow read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | AW | Read data, right-aligned |

## Verification
The checker verifies on every cycle the request hold rule under back-pressure, the one-cycle shape of the completion pulse and its coincidence with `busy` falling, the stickiness of the missed-event flag, the one-cycle read latency, and the effect of a load on `busy`. Only the bench scenarios can show the address arithmetic. A sweep over BCNT and CCNT, with strides that push the destination across a 16-bit carry, compares each request and word read against addresses computed in the bench. Dedicated scenarios cover a read that coincides with an update, a byte-wise walk across an update, a dropped event, and events after completion.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    RD_BYTE = 2'd0,
    RD_HALF = 2'd1,
    RD_WORD = 2'd2
  } rd_size_e;
endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] src0,
  input  logic [AW-1:0] dst0,
  input  logic [CW-1:0] bcnt0,
  input  logic [CW-1:0] ccnt0,
  input  logic [IW-1:0] src_astep,
  input  logic [IW-1:0] dst_astep,
  input  logic [IW-1:0] src_fstep,
  input  logic [IW-1:0] dst_fstep,
  input  logic          step,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst,
  output logic          active,
  output logic          done
);
  localparam int XW = AW - IW;

  logic [CW-1:0] b_reload, b_left, c_left;
  logic [AW-1:0] sa_q, da_q, sf_q, df_q;

  function automatic logic [AW-1:0] sext(input logic [IW-1:0] v);
    return {{XW{v[IW-1]}}, v};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_src  <= '0;
      cur_dst  <= '0;
      b_reload <= '0;
      b_left   <= '0;
      c_left   <= '0;
      sa_q     <= '0;
      da_q     <= '0;
      sf_q     <= '0;
      df_q     <= '0;
      active   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        cur_src  <= src0;
        cur_dst  <= dst0;
        b_reload <= (bcnt0 == '0) ? CW'(1) : bcnt0;
        b_left   <= (bcnt0 == '0) ? CW'(1) : bcnt0;
        c_left   <= ccnt0;
        sa_q     <= sext(src_astep);
        da_q     <= sext(dst_astep);
        sf_q     <= sext(src_fstep);
        df_q     <= sext(dst_fstep);
        active   <= (ccnt0 != '0);
      end else if (step && active) begin
        if (b_left > CW'(1)) begin
          cur_src <= cur_src + sa_q;
          cur_dst <= cur_dst + da_q;
          b_left  <= b_left - CW'(1);
        end else begin
          cur_src <= cur_src + sf_q;
          cur_dst <= cur_dst + df_q;
          b_left  <= b_reload;
          c_left  <= c_left - CW'(1);
          if (c_left == CW'(1)) begin
            active <= 1'b0;
            done   <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dma_req_stage.sv
module dma_req_stage #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] acnt0,
  input  logic          evt,
  input  logic          active,
  input  logic [AW-1:0] cur_src,
  input  logic [AW-1:0] cur_dst,
  input  logic          req_ready,
  output logic          req_valid,
  output logic [AW-1:0] req_src,
  output logic [AW-1:0] req_dst,
  output logic [CW-1:0] req_bytes,
  output logic          take,
  output logic          missed
);
  logic [CW-1:0] acnt_q;

  assign take = evt && active && !req_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acnt_q    <= '0;
      req_valid <= 1'b0;
      req_src   <= '0;
      req_dst   <= '0;
      req_bytes <= '0;
      missed    <= 1'b0;
    end else begin
      if (load) acnt_q <= acnt0;
      if (take) begin
        req_valid <= 1'b1;
        req_src   <= cur_src;
        req_dst   <= cur_dst;
        req_bytes <= acnt_q;
      end else if (req_valid && req_ready) begin
        req_valid <= 1'b0;
      end
      if (load) missed <= 1'b0;
      else if (evt && active && req_valid) missed <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_rd_port.sv
module dma_rd_port #(
  parameter int DW = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_rd,
  input  logic [1:0]               size,
  input  logic [$clog2(DW/8)-1:0]  off,
  input  logic [DW-1:0]            live,
  output logic                     rd_valid,
  output logic [DW-1:0]            rd_data
);
  import dma_seq_pkg::*;
  localparam int OW = $clog2(DW/8);

  logic [DW-1:0] hold, base, shifted, data_n;
  logic          narrow;
  logic [OW-1:0] sh_amt;

  always_comb begin
    narrow  = (size == RD_BYTE) || (size == RD_HALF);
    sh_amt  = narrow ? off : '0;
    base    = (!narrow || off == '0) ? live : hold;
    shifted = base >> {sh_amt, 3'b000};
    case (size)
      RD_BYTE: data_n = {{(DW-8){1'b0}}, shifted[7:0]};
      RD_HALF: data_n = {{(DW-16){1'b0}}, shifted[15:0]};
      default: data_n = shifted;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cpu_rd;
      if (cpu_rd) begin
        rd_data <= data_n;
        if (narrow && off == '0) hold <= live;
      end
    end
  end
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int IW = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_load,
  input  logic [AW-1:0]            cfg_src,
  input  logic [AW-1:0]            cfg_dst,
  input  logic [CW-1:0]            cfg_acnt,
  input  logic [CW-1:0]            cfg_bcnt,
  input  logic [CW-1:0]            cfg_ccnt,
  input  logic [IW-1:0]            cfg_src_astep,
  input  logic [IW-1:0]            cfg_dst_astep,
  input  logic [IW-1:0]            cfg_src_fstep,
  input  logic [IW-1:0]            cfg_dst_fstep,
  input  logic                     sync_evt,
  output logic                     req_valid,
  input  logic                     req_ready,
  output logic [AW-1:0]            req_src,
  output logic [AW-1:0]            req_dst,
  output logic [CW-1:0]            req_bytes,
  output logic                     busy,
  output logic                     done,
  output logic                     missed_evt,
  input  logic                     cpu_rd,
  input  logic [1:0]               cpu_rd_size,
  input  logic [$clog2(AW/8)-1:0]  cpu_rd_off,
  output logic                     rd_valid,
  output logic [AW-1:0]            rd_data
);
  logic [AW-1:0] cur_src, cur_dst;
  logic          take;

  dma_addr_gen #(.AW(AW), .CW(CW), .IW(IW)) u_gen (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .src0(cfg_src), .dst0(cfg_dst), .bcnt0(cfg_bcnt), .ccnt0(cfg_ccnt),
    .src_astep(cfg_src_astep), .dst_astep(cfg_dst_astep),
    .src_fstep(cfg_src_fstep), .dst_fstep(cfg_dst_fstep),
    .step(take), .cur_src(cur_src), .cur_dst(cur_dst),
    .active(busy), .done(done)
  );

  dma_req_stage #(.AW(AW), .CW(CW)) u_req (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .acnt0(cfg_acnt),
    .evt(sync_evt), .active(busy), .cur_src(cur_src), .cur_dst(cur_dst),
    .req_ready(req_ready), .req_valid(req_valid), .req_src(req_src),
    .req_dst(req_dst), .req_bytes(req_bytes), .take(take), .missed(missed_evt)
  );

  dma_rd_port #(.DW(AW)) u_rd (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .size(cpu_rd_size),
    .off(cpu_rd_off), .live(cur_dst), .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_load,
  input logic [CW-1:0] cfg_ccnt,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_src,
  input logic [AW-1:0] req_dst,
  input logic [CW-1:0] req_bytes,
  input logic          busy,
  input logic          done,
  input logic          missed_evt,
  input logic          cpu_rd,
  input logic          rd_valid
);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_src) &&
                                   $stable(req_dst) && $stable(req_bytes)));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_missed_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (missed_evt && !cfg_load) |=> missed_evt);

  assert_rd_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd |=> rd_valid);

  assert_rd_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |=> !rd_valid);

  assert_load_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (!missed_evt && (busy == ($past(cfg_ccnt) != '0))));
endmodule

bind dma_addr_seq dma_addr_seq_chk #(.AW(AW), .CW(CW)) u_chk (.*);

// File: tb/dma_addr_seq_tb.sv
module dma_addr_seq_tb;
  localparam int AW = 32, CW = 16, IW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 0;
  logic [AW-1:0] cfg_src = 0, cfg_dst = 0;
  logic [CW-1:0] cfg_acnt = 0, cfg_bcnt = 0, cfg_ccnt = 0;
  logic [IW-1:0] cfg_src_astep = 0, cfg_dst_astep = 0, cfg_src_fstep = 0, cfg_dst_fstep = 0;
  logic sync_evt = 0, req_ready = 1, cpu_rd = 0;
  logic [1:0] cpu_rd_size = 2;
  logic [1:0] cpu_rd_off = 0;
  logic req_valid, busy, done, missed_evt, rd_valid;
  logic [AW-1:0] req_src, req_dst, rd_data;
  logic [CW-1:0] req_bytes;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [AW-1:0] ms, md, sa, da, sf, df;
  int bl, cl, bload;

  always #5 clk = ~clk;

  dma_addr_seq #(.AW(AW), .CW(CW), .IW(IW)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [AW-1:0] s, input logic [AW-1:0] d, input int b, input int c,
                      input logic [IW-1:0] s_a, input logic [IW-1:0] d_a,
                      input logic [IW-1:0] s_f, input logic [IW-1:0] d_f);
    @(negedge clk);
    cfg_src = s; cfg_dst = d; cfg_acnt = 16'd64; cfg_bcnt = CW'(b); cfg_ccnt = CW'(c);
    cfg_src_astep = s_a; cfg_dst_astep = d_a; cfg_src_fstep = s_f; cfg_dst_fstep = d_f;
    cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
    ms = s; md = d; bload = (b == 0) ? 1 : b; bl = bload; cl = c;
    sa = {{(AW-IW){s_a[IW-1]}}, s_a}; da = {{(AW-IW){d_a[IW-1]}}, d_a};
    sf = {{(AW-IW){s_f[IW-1]}}, s_f}; df = {{(AW-IW){d_f[IW-1]}}, d_f};
  endtask

  // model advance after an accepted event; returns 1 when the transfer ends
  function automatic bit advance();
    if (bl > 1) begin ms += sa; md += da; bl--; return 0; end
    ms += sf; md += df; bl = bload; cl--;
    return (cl == 0);
  endfunction

  task automatic word_read(output logic [AW-1:0] v);
    cpu_rd = 1; cpu_rd_size = 2; cpu_rd_off = 0;
    @(negedge clk);
    cpu_rd = 0;
    v = rd_data;
  endtask

  task automatic narrow_read(input logic [1:0] sz, input logic [1:0] off, output logic [AW-1:0] v);
    cpu_rd = 1; cpu_rd_size = sz; cpu_rd_off = off;
    @(negedge clk);
    cpu_rd = 0;
    v = rd_data;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [AW-1:0] v, prev, exp_s, exp_d;
    bit last;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !req_valid && !done && !missed_evt && !rd_valid, "R1 reset idle",
        {busy, req_valid, done, missed_evt, rd_valid}, 0);

    // Sweep BCNT and CCNT; destination crosses a 16-bit carry
    for (int b = 0; b <= 3; b++) begin
      for (int c = 1; c <= 3; c++) begin
        load(32'h0000_1000, 32'h0000_FFE0, b, c, 16'h0020, 16'h0010, 16'h0007, 16'h0030);
        chk(busy, "R1 busy after load", busy, 1);
        prev = 0;
        for (int e = 0; e < ((b == 0) ? 1 : b) * c; e++) begin
          exp_s = ms; exp_d = md;
          sync_evt = 1;
          @(negedge clk);
          sync_evt = 0;
          last = advance();
          chk(req_valid && req_src == exp_s && req_dst == exp_d && req_bytes == 16'd64,
              "R2 request fields", req_dst, exp_d);
          chk(done == last, last ? "R5 done on last" : "R4 no early done", done, last);
          chk(busy == !last, "R4 busy during transfer", busy, !last);
          @(negedge clk);
          chk(!req_valid && !done, "R2 request consumed, R5 pulse ends", {req_valid, done}, 0);
          word_read(v);
          chk(v == md, "R3 R4 live destination", v, md);
          chk(v >= prev, "R9 monotonic destination", v, prev);
          prev = v;
        end
        // R5 events after completion are ignored
        sync_evt = 1;
        @(negedge clk);
        sync_evt = 0;
        chk(!req_valid && !busy, "R5 event after done ignored", req_valid, 0);
        word_read(v);
        chk(v == md, "R5 address frozen after done", v, md);
      end
    end

    // R7 read coinciding with an update returns pre-update value
    load(32'h0, 32'h0000_2000, 2, 2, 16'h4, 16'h100, 16'h8, 16'h200);
    exp_d = md;
    sync_evt = 1; cpu_rd = 1; cpu_rd_size = 2; cpu_rd_off = 0;
    @(negedge clk);
    sync_evt = 0; cpu_rd = 0;
    void'(advance());
    chk(rd_valid && rd_data == exp_d, "R7 same-cycle read pre-update", rd_data, exp_d);
    word_read(v);
    chk(v == md, "R7 read after update", v, md);

    // R8 byte walk across an update stays coherent
    load(32'h0, 32'h0000_FFF8, 1, 4, 16'h0, 16'h0, 16'h0, 16'h0008);
    narrow_read(2'd0, 2'd0, v);
    chk(v == 32'h0000_00F8, "R8 byte0 live", v, 32'hF8);
    sync_evt = 1;
    @(negedge clk);
    sync_evt = 0;
    void'(advance());
    @(negedge clk);
    narrow_read(2'd0, 2'd1, v);
    chk(v == 32'h0000_00FF, "R8 byte1 from snapshot", v, 32'hFF);
    narrow_read(2'd0, 2'd2, v);
    chk(v == 32'h0, "R8 byte2 from snapshot", v, 32'h0);
    narrow_read(2'd1, 2'd2, v);
    chk(v == 32'h0, "R8 upper half from snapshot", v, 32'h0);
    narrow_read(2'd1, 2'd0, v);
    chk(v == 32'h0, "R8 lower half live", v, 32'h0);
    narrow_read(2'd1, 2'd2, v);
    chk(v == 32'h0000_0001, "R8 upper half after re-snapshot", v, 32'h1);
    word_read(v);
    chk(v == 32'h0001_0000, "R7 word after carry", v, 32'h0001_0000);

    // R6 event during pending request is dropped and flagged
    load(32'h0, 32'h0000_4000, 1, 5, 16'h0, 16'h0, 16'h0, 16'h0040);
    req_ready = 0;
    exp_d = md;
    sync_evt = 1;
    @(negedge clk);
    void'(advance());
    @(negedge clk);
    sync_evt = 0;
    chk(missed_evt, "R6 missed flag set", missed_evt, 1);
    chk(req_valid && req_dst == exp_d, "R2 R6 request held under stall", req_dst, exp_d);
    repeat (2) @(negedge clk);
    chk(missed_evt && req_valid, "R6 flag sticky", missed_evt, 1);
    req_ready = 1;
    @(negedge clk);
    word_read(v);
    chk(v == md, "R6 dropped event did not advance", v, md);
    load(32'h0, 32'h0000_4000, 1, 5, 16'h0, 16'h0, 16'h0, 16'h0040);
    chk(!missed_evt, "R1 load clears missed flag", missed_evt, 0);

    // R1 load with CCNT zero leaves channel idle
    load(32'h0, 32'h0000_5000, 1, 0, 16'h0, 16'h0, 16'h0, 16'h0040);
    chk(!busy, "R1 zero frame count idle", busy, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule